// File: doc/BRIEF.md
# SD Host Vendor Register Front-End

This block is the register front-end of an SD/eMMC host controller. It decodes a 4 KiB window on a simple 32-bit register bus. The lower 512 bytes hold a small set of vendor host registers. The rest of the window is passed to a separate port that serves the standard slot register set. When it is passed on, the address has the slot base subtracted and the strobes and write data are forwarded in the same cycle.

Three vendor registers change the written value as it is stored:

- The general-information register at offset 0x00 holds a fixed identification value. Setting its bit 0 starts a software reset. That reset restores every vendor register and sends a one-cycle reset pulse to the slot logic.
- The PHY access register at offset 0x10 raises an acknowledge bit as soon as a read or write request is written.
- The tuning request bit of the eMMC control register at offset 0x18 is never kept.

Read data appears one cycle after the read strobe. The slot port's interrupt request passes straight through to the block's interrupt output.

Top module: `sdhost_vreg_front`

## Requirements
- R1: After hardware reset, every vendor register reads 0, except offset 0x00, which reads 0x00010000.
- R2: Every vendor offset below 0x200 other than 0x00, 0x10 and 0x18 stores all 32 written bits. A read returns the stored value on bus_rdata in the cycle after bus_re is sampled.
- R3: A write to offset 0x00 with bit 0 = 1 restores every vendor register to its R1 value from the next cycle. Any write to offset 0x00 with bit 0 = 0 changes nothing. Offset 0x00 always reads 0x00010000, so bit 0 reads 0.
- R4: slot_reset is high while rst_n is low. After reset it is high for exactly the one cycle that follows a software-reset write, and low otherwise.
- R5: At offset 0x10, bit 26 is stored as 1 when bit 24 or bit 25 of the written value is 1. Otherwise bit 26 is stored as 0. All other bits are stored as written.
- R6: At offset 0x18, bit 15 is always stored as 0 and all other written bits are kept.
- R7: An aligned access at offset 0x200 or above drives slot_we or slot_re in the same cycle, with slot_addr = offset − 0x200 and slot_wdata = bus_wdata. Such an access leaves the vendor registers unchanged.
- R8: An aligned read at offset 0x200 or above returns slot_rdata on bus_rdata in the following cycle. The slot port is expected to present its data in that cycle.
- R9: An access whose address bits [1:0] are not 0 is ignored. It writes no vendor register, raises no slot strobe, and reads back as 0.
- R10: irq always equals slot_irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte offset within the window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after bus_re |
| slot_addr | output | 12 | Offset into the slot register set |
| slot_we | output | 1 | Slot write strobe |
| slot_wdata | output | 32 | Slot write data |
| slot_re | output | 1 | Slot read strobe |
| slot_rdata | input | 32 | Slot read data, one cycle after slot_re |
| slot_reset | output | 1 | Reset to the slot logic |
| slot_irq | input | 1 | Slot interrupt request |
| irq | output | 1 | Interrupt output |

## Verification
The assertions check on every cycle:

- the one-cycle shape of the slot reset pulse;
- the fixed readback of offset 0x00;
- the acknowledge and tuning rules at offsets 0x10 and 0x18;
- that unaligned writes and slot-range writes leave the vendor storage untouched.

Only the bench scenarios show the following:

- the full restore after a software reset, with registers written beforehand;
- the exact subtracted slot address and the read-data mux switching between slot and vendor data;
- unaligned reads returning zero while the slot port offers nonzero data.

// File: rtl/sdhost_vreg_front.sv
module sdhost_vreg_front #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SLOT_BASE   = 512,
  parameter logic [DATA_W-1:0] ID_INIT = 32'h0001_0000,
  parameter int PHY_IDX     = 4,
  parameter int TUNE_IDX    = 6,
  parameter int PHY_WR_BIT  = 24,
  parameter int PHY_RD_BIT  = 25,
  parameter int PHY_ACK_BIT = 26,
  parameter int TUNE_BIT    = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] slot_addr,
  output logic              slot_we,
  output logic [DATA_W-1:0] slot_wdata,
  output logic              slot_re,
  input  logic [DATA_W-1:0] slot_rdata,
  output logic              slot_reset,
  input  logic              slot_irq,
  output logic              irq
);
  localparam int VREG_CNT = SLOT_BASE / 4;
  localparam int IDX_W    = $clog2(VREG_CNT);

  logic [VREG_CNT-1:0][DATA_W-1:0] vreg;
  logic [DATA_W-1:0] rdata_q, wval;
  logic              slot_sel_q, slot_rst_q;

  logic             aligned, in_slot, vwr, vrd, swr_hit;
  logic [IDX_W-1:0] widx;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign in_slot = (bus_addr >= ADDR_W'(SLOT_BASE));
  assign vwr     = bus_we & aligned & ~in_slot;
  assign vrd     = bus_re & aligned & ~in_slot;
  assign widx    = bus_addr[IDX_W+1:2];
  assign swr_hit = vwr && (widx == IDX_W'(0)) && bus_wdata[0];

  assign slot_addr  = bus_addr - ADDR_W'(SLOT_BASE);
  assign slot_we    = bus_we & aligned & in_slot;
  assign slot_re    = bus_re & aligned & in_slot;
  assign slot_wdata = bus_wdata;
  assign slot_reset = slot_rst_q;
  assign irq        = slot_irq;
  assign bus_rdata  = slot_sel_q ? slot_rdata : rdata_q;

  always_comb begin
    wval = bus_wdata;
    if (widx == IDX_W'(PHY_IDX))
      wval[PHY_ACK_BIT] = bus_wdata[PHY_WR_BIT] | bus_wdata[PHY_RD_BIT];
    if (widx == IDX_W'(TUNE_IDX))
      wval[TUNE_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vreg       <= '0;
      vreg[0]    <= ID_INIT;
      rdata_q    <= '0;
      slot_sel_q <= 1'b0;
      slot_rst_q <= 1'b1;
    end else begin
      slot_rst_q <= swr_hit;
      slot_sel_q <= slot_re;
      rdata_q    <= vrd ? vreg[widx] : '0;
      if (swr_hit) begin
        vreg    <= '0;
        vreg[0] <= ID_INIT;
      end else if (vwr && widx != IDX_W'(0)) begin
        vreg[widx] <= wval;
      end
    end
  end

  assert_swr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    swr_hit |=> slot_reset);
  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !swr_hit |=> !slot_reset);
  assert_swr_restore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    swr_hit |=> (vreg[PHY_IDX] == '0 && vreg[TUNE_IDX] == '0 && vreg[1] == '0));
  assert_id_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vrd && widx == IDX_W'(0)) |=> bus_rdata == ID_INIT);
  assert_phy_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vwr && widx == IDX_W'(PHY_IDX)) |=>
      vreg[PHY_IDX][PHY_ACK_BIT] == ($past(bus_wdata[PHY_WR_BIT]) | $past(bus_wdata[PHY_RD_BIT])));
  assert_tune_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vwr && widx == IDX_W'(TUNE_IDX)) |=> !vreg[TUNE_IDX][TUNE_BIT]);
  assert_unaligned_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !aligned) |=> $stable(vreg));
  assert_slot_write_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && in_slot) |=> $stable(vreg));
endmodule

// File: tb/sdhost_vreg_front_test.sv
module sdhost_vreg_front_test;
  logic        clk = 0, rst_n = 0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 0, bus_re = 0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [11:0] slot_addr;
  logic        slot_we, slot_re, slot_reset, irq;
  logic [31:0] slot_wdata, slot_rdata = '0;
  logic        slot_irq = 0;
  int          tests = 0, fails = 0;

  always #2 clk = ~clk;

  sdhost_vreg_front uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .slot_addr(slot_addr), .slot_we(slot_we), .slot_wdata(slot_wdata),
    .slot_re(slot_re), .slot_rdata(slot_rdata), .slot_reset(slot_reset),
    .slot_irq(slot_irq), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1;
    @(posedge clk); @(negedge clk);
    d = bus_rdata; bus_re = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R4 reset held", 32'(slot_reset), 1);
    rd(12'h000, v); check("R1 id", v, 32'h0001_0000);
    rd(12'h004, v); check("R1 reg04", v, 0);
    rd(12'h010, v); check("R1 phy", v, 0);
    rd(12'h1FC, v); check("R1 last", v, 0);
    check("R4 after reset", 32'(slot_reset), 0);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    wr(12'h004, 32'hA5A5_5A5A);
    wr(12'h1FC, 32'h1234_5678);
    rd(12'h004, v); check("R2 reg04", v, 32'hA5A5_5A5A);
    rd(12'h1FC, v); check("R2 reg1FC", v, 32'h1234_5678);
    rd(12'h040, v); check("R2 untouched", v, 0);
  endtask

  task automatic t_swr();
    logic [31:0] v;
    wr(12'h008, 32'hDEAD_BEEF);
    wr(12'h000, 32'hFFFF_FFFE);
    check("R4 no pulse", 32'(slot_reset), 0);
    rd(12'h000, v); check("R3 id kept", v, 32'h0001_0000);
    rd(12'h008, v); check("R3 no reset", v, 32'hDEAD_BEEF);
    wr(12'h000, 32'h0000_0001);
    check("R4 pulse", 32'(slot_reset), 1);
    @(posedge clk); @(negedge clk);
    check("R4 pulse end", 32'(slot_reset), 0);
    rd(12'h008, v); check("R3 reg08 cleared", v, 0);
    rd(12'h004, v); check("R3 reg04 cleared", v, 0);
    rd(12'h000, v); check("R3 id", v, 32'h0001_0000);
  endtask

  task automatic t_phy();
    logic [31:0] v;
    wr(12'h010, 32'h0100_0000); rd(12'h010, v); check("R5 wr req", v, 32'h0500_0000);
    wr(12'h010, 32'h0200_00FF); rd(12'h010, v); check("R5 rd req", v, 32'h0600_00FF);
    wr(12'h010, 32'h0400_0012); rd(12'h010, v); check("R5 no req", v, 32'h0000_0012);
    wr(12'h010, 32'h0300_0000); rd(12'h010, v); check("R5 both", v, 32'h0700_0000);
  endtask

  task automatic t_tune();
    logic [31:0] v;
    wr(12'h018, 32'hFFFF_FFFF); rd(12'h018, v); check("R6 all", v, 32'hFFFF_7FFF);
    wr(12'h018, 32'h0000_8000); rd(12'h018, v); check("R6 only", v, 0);
  endtask

  task automatic t_slot();
    logic [31:0] v;
    bus_addr = 12'h234; bus_wdata = 32'h0BAD_F00D; bus_we = 1;
    #1;
    check("R7 slot_we", 32'(slot_we), 1);
    check("R7 slot_re idle", 32'(slot_re), 0);
    check("R7 slot_addr", 32'(slot_addr), 32'h034);
    check("R7 slot_wdata", slot_wdata, 32'h0BAD_F00D);
    @(posedge clk); @(negedge clk); bus_we = 0;
    wr(12'h204, 32'h5555_AAAA);
    rd(12'h004, v); check("R7 vendor untouched", v, 0);
    slot_rdata = 32'hCAFE_F00D;
    bus_addr = 12'h200; bus_re = 1;
    #1;
    check("R7 slot_re", 32'(slot_re), 1);
    check("R7 slot_addr base", 32'(slot_addr), 0);
    @(posedge clk); @(negedge clk);
    check("R8 slot data", bus_rdata, 32'hCAFE_F00D);
    bus_re = 0;
    rd(12'h000, v); check("R8 back to vendor", v, 32'h0001_0000);
  endtask

  task automatic t_unaligned();
    logic [31:0] v;
    wr(12'h00C, 32'h0000_0011);
    wr(12'h00E, 32'h0000_0022);
    rd(12'h00C, v); check("R9 write ignored", v, 32'h0000_0011);
    bus_addr = 12'h202; bus_we = 1; #1;
    check("R9 no slot_we", 32'(slot_we), 0);
    @(posedge clk); @(negedge clk); bus_we = 0;
    rd(12'h00D, v); check("R9 read zero", v, 0);
    bus_addr = 12'h201; bus_re = 1; #1;
    check("R9 no slot_re", 32'(slot_re), 0);
    @(posedge clk); @(negedge clk);
    check("R9 slot read zero", bus_rdata, 0);
    bus_re = 0;
  endtask

  task automatic t_irq();
    slot_irq = 1; #1; check("R10 high", 32'(irq), 1);
    slot_irq = 0; #1; check("R10 low", 32'(irq), 0);
  endtask

  initial begin
    #5;
    t_irq();
    @(negedge clk); @(negedge clk);
    check("R4 in reset", 32'(slot_reset), 1);
    rst_n = 1;
    t_reset();
    t_plain();
    t_swr();
    t_phy();
    t_tune();
    t_slot();
    t_unaligned();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule